// File: doc/BRIEF.md
# Indexed Colour Palette with Flashing Entries

This block turns a 4-bit logical pixel colour into a 3-bit RGB value. It keeps a table of sixteen entries, one for each logical colour. A processor fills the table one byte at a time. The upper nibble of the byte picks the entry, and the lower nibble is the physical colour code to store there.

Physical codes are written in inverted form: the three colour bits hold the colour XOR 7. Bit 3 of a code marks the entry as flashing. A flashing entry shows its colour or the bitwise complement of that colour, and a single global flash phase picks which one. That phase comes from a separate control-register write port. A small two-state machine holds it, with the states FLASH_FIRST (the plain colour is shown) and FLASH_SECOND (the complement is shown). A control write carrying 1 takes the machine from FLASH_FIRST to FLASH_SECOND. A control write carrying 0 takes it back. Any other cycle stays in the current state.

On each pixel clock the block reads the entry chosen by the pixel index, decodes it, applies the flash phase and registers the result. While blanking is asserted the registered output is forced to black. In modes with few colours, the software writes every entry that shares the pixel bits in use. The block treats all sixteen entries alike.

Top module: `pal_colour_map`

## Requirements
- R1: While reset is asserted, rgb_out is 000. After reset the flash machine is in FLASH_FIRST, and entry n displays colour (n mod 8) with its flash bit clear, for every n from 0 to 15.
- R2: A palette write (pal_wr_en high at a clock edge) stores pal_wr_data[3:0] into the entry numbered pal_wr_data[7:4]. When that entry is shown, the displayed colour is the stored bits [2:0] XOR 3'b111. rgb_out bit 0 is red, bit 1 is green and bit 2 is blue.
- R3: rgb_out shows the colour for the pix_index and pix_blank sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R4: When pix_blank is high at a clock edge, rgb_out is 000 after that edge, whatever the index and the table contents.
- R5: A control write (ctl_wr_en high) sets the flash phase to ctl_wr_flash: 1 moves to FLASH_SECOND and 0 moves to FLASH_FIRST. Without a control write the phase is held.
- R6: An entry whose stored bit 3 is 1 displays its decoded colour in FLASH_FIRST and the bitwise complement of that colour in FLASH_SECOND.
- R7: An entry whose stored bit 3 is 0 displays its decoded colour in both flash states.
- R8: A palette write changes only the addressed entry. All other entries keep their displayed colour.
- R9: A palette write takes effect after its clock edge. A pixel sampled at the same edge as the write shows the old contents, and the next pixel shows the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all writes also use this clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_wr_en | input | 1 | Palette write strobe |
| pal_wr_data | input | 8 | Bits 7:4 are the entry index; bits 3:0 are the stored code (flash bit, then the inverted colour) |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_flash | input | 1 | Flash phase carried by a control write |
| pix_index | input | 4 | Logical colour of the current pixel |
| pix_blank | input | 1 | Blanking; forces the output to black |
| rgb_out | output | 3 | Registered colour: bit 0 red, bit 1 green, bit 2 blue |

## Verification
All sixteen indices are read straight after reset. A wrong reset code or a bit-order slip in the decode therefore shows up as a wrong colour at a known index. Writes of chosen nibbles to chosen entries check the XOR-7 decode and the red, green and blue bit positions. Reading the neighbouring entries afterwards catches a write that lands on the wrong entry. A steady entry and a flashing entry are read under both flash states, including the black/white pair, which separates the complement path from the plain path. Separate directed patterns hold the index across a write, change the index one cycle before sampling, and toggle blanking. These tell apart an output that is one cycle late, a write that shows through early, and blanking applied on the wrong cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int PAL_IDX_W = 4;
    localparam int PAL_RGB_W = 3;

    typedef enum logic {
        FLASH_FIRST  = 1'b0,
        FLASH_SECOND = 1'b1
    } flash_state_e;

endpackage

// File: rtl/pal_flash_ctl.sv
module pal_flash_ctl
    import pal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_en,
    input  logic ctl_wr_flash,
    output logic flash_on
);

    flash_state_e state_q;
    flash_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLASH_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLASH_FIRST: begin
                if (ctl_wr_en && ctl_wr_flash) begin
                    state_d = FLASH_SECOND;
                end
            end
            FLASH_SECOND: begin
                if (ctl_wr_en && !ctl_wr_flash) begin
                    state_d = FLASH_FIRST;
                end
            end
            default: state_d = FLASH_FIRST;
        endcase
    end

    always_comb begin
        flash_on = (state_q == FLASH_SECOND);
    end

    // R5
    flash_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (flash_on == $past(ctl_wr_flash)));

    // R5
    flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_en |=> $stable(flash_on));

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W = pal_pkg::PAL_IDX_W,
    parameter int RGB_W = pal_pkg::PAL_RGB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W:0]   wr_code,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W:0]   rd_code
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int CODE_W  = RGB_W + 1;

    logic [CODE_W-1:0] mem [ENTRIES];

    function automatic logic [CODE_W-1:0] boot_code(input int n);
        logic [RGB_W-1:0] shade;
        shade = RGB_W'(n) ^ {RGB_W{1'b1}};
        return {1'b0, shade};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem[e] <= boot_code(e);
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_code;
        end
    end

    assign rd_code = mem[rd_idx];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry_chk
            // R2
            entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_idx == IDX_W'(g))) |=> (mem[g] == $past(wr_code)));

            // R8
            entry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && (wr_idx == IDX_W'(g))) |=> $stable(mem[g]));
        end
    endgenerate

endmodule

// File: rtl/pal_resolve.sv
module pal_resolve #(
    parameter int RGB_W = pal_pkg::PAL_RGB_W
) (
    input  logic [RGB_W:0]   code,
    input  logic             flash_on,
    output logic [RGB_W-1:0] rgb
);

    logic [RGB_W-1:0] shade;
    logic             is_flashing;

    always_comb begin
        shade       = code[RGB_W-1:0] ^ {RGB_W{1'b1}};
        is_flashing = code[RGB_W];
        if (is_flashing && flash_on) begin
            rgb = ~shade;
        end else begin
            rgb = shade;
        end
    end

endmodule

// File: rtl/pal_colour_map.sv
module pal_colour_map #(
    parameter int IDX_W = pal_pkg::PAL_IDX_W,
    parameter int RGB_W = pal_pkg::PAL_RGB_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pal_wr_en,
    input  logic [IDX_W+RGB_W:0]     pal_wr_data,
    input  logic                     ctl_wr_en,
    input  logic                     ctl_wr_flash,
    input  logic [IDX_W-1:0]         pix_index,
    input  logic                     pix_blank,
    output logic [RGB_W-1:0]         rgb_out
);

    localparam int CODE_W = RGB_W + 1;
    localparam int WR_W   = IDX_W + CODE_W;

    logic [IDX_W-1:0]  wr_idx;
    logic [CODE_W-1:0] wr_code;
    logic [CODE_W-1:0] rd_code;
    logic              flash_on;
    logic [RGB_W-1:0]  rgb_d;

    assign wr_idx  = pal_wr_data[WR_W-1:CODE_W];
    assign wr_code = pal_wr_data[CODE_W-1:0];

    pal_store #(
        .IDX_W (IDX_W),
        .RGB_W (RGB_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_wr_en),
        .wr_idx  (wr_idx),
        .wr_code (wr_code),
        .rd_idx  (pix_index),
        .rd_code (rd_code)
    );

    pal_flash_ctl flash_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_flash (ctl_wr_flash),
        .flash_on     (flash_on)
    );

    pal_resolve #(
        .RGB_W (RGB_W)
    ) resolve_i (
        .code     (rd_code),
        .flash_on (flash_on),
        .rgb      (rgb_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_out <= '0;
        end else if (pix_blank) begin
            rgb_out <= '0;
        end else begin
            rgb_out <= rgb_d;
        end
    end

    // R4
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_blank |=> (rgb_out == '0));

endmodule

// File: tb/pal_colour_map_tb.sv
`timescale 1ns/1ps
module pal_colour_map_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pal_wr_en = 1'b0;
    logic [7:0] pal_wr_data = 8'h00;
    logic       ctl_wr_en = 1'b0;
    logic       ctl_wr_flash = 1'b0;
    logic [3:0] pix_index = 4'h0;
    logic       pix_blank = 1'b0;
    logic [2:0] rgb_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pal_colour_map dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pal_wr_en    (pal_wr_en),
        .pal_wr_data  (pal_wr_data),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_flash (ctl_wr_flash),
        .pix_index    (pix_index),
        .pix_blank    (pix_blank),
        .rgb_out      (rgb_out)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: rgb_out=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pal_write(input logic [3:0] idx, input logic [3:0] nib);
        @(negedge clk);
        pal_wr_en   = 1'b1;
        pal_wr_data = {idx, nib};
        @(negedge clk);
        pal_wr_en   = 1'b0;
    endtask

    task automatic ctl_write(input logic ph);
        @(negedge clk);
        ctl_wr_en    = 1'b1;
        ctl_wr_flash = ph;
        @(negedge clk);
        ctl_wr_en    = 1'b0;
    endtask

    task automatic show(input logic [3:0] idx, input logic blank,
                        input logic [2:0] exp, input string tag);
        @(negedge clk);
        pix_index = idx;
        pix_blank = blank;
        @(posedge clk);
        #1;
        check(tag, rgb_out, exp);
    endtask

    task automatic t_reset();
        @(posedge clk);
        #1;
        check("R1 output during reset", rgb_out, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 16; n++) begin
            show(4'(n), 1'b0, 3'(n), "R1 reset entry colour");
        end
    endtask

    task automatic t_write_decode();
        pal_write(4'h5, 4'h5);
        show(4'h5, 1'b0, 3'b010, "R2 stored 5 shows green");
        pal_write(4'h5, 4'h6);
        show(4'h5, 1'b0, 3'b001, "R2 red is bit 0");
        pal_write(4'h5, 4'h3);
        show(4'h5, 1'b0, 3'b100, "R2 blue is bit 2");
        show(4'h4, 1'b0, 3'd4, "R8 neighbour below untouched");
        show(4'h6, 1'b0, 3'd6, "R8 neighbour above untouched");
        show(4'hD, 1'b0, 3'd5, "R8 alias entry untouched");
    endtask

    task automatic t_latency();
        show(4'h3, 1'b0, 3'd3, "R3 steady index");
        @(negedge clk);
        pix_index = 4'h9;
        #2;
        check("R3 old colour before edge", rgb_out, 3'd3);
        @(posedge clk);
        #1;
        check("R3 new colour after one edge", rgb_out, 3'd1);
    endtask

    task automatic t_blank();
        show(4'h7, 1'b1, 3'b000, "R4 blank forces black");
        show(4'h7, 1'b0, 3'b111, "R4 unblank restores colour");
    endtask

    task automatic t_flash();
        pal_write(4'h2, 4'hE);
        pal_write(4'h3, 4'hF);
        show(4'h2, 1'b0, 3'b001, "R6 flashing red in first phase");
        show(4'h3, 1'b0, 3'b000, "R6 flashing black in first phase");
        ctl_write(1'b1);
        show(4'h2, 1'b0, 3'b110, "R6 flashing red shows cyan");
        show(4'h3, 1'b0, 3'b111, "R6 flashing black shows white");
        show(4'h4, 1'b0, 3'd4, "R7 steady entry in second phase");
        ctl_write(1'b1);
        show(4'h2, 1'b0, 3'b110, "R5 repeated phase 1 holds");
        ctl_write(1'b0);
        show(4'h2, 1'b0, 3'b001, "R5 phase back to first");
        show(4'h4, 1'b0, 3'd4, "R7 steady entry in first phase");
    endtask

    task automatic t_same_cycle();
        show(4'hA, 1'b0, 3'd2, "R9 entry before write");
        @(negedge clk);
        pal_wr_en   = 1'b1;
        pal_wr_data = {4'hA, 4'h2};
        @(posedge clk);
        #1;
        check("R9 same-edge read sees old", rgb_out, 3'd2);
        @(negedge clk);
        pal_wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R9 next read sees new", rgb_out, 3'd5);
    endtask

    initial begin
        t_reset();
        t_write_decode();
        t_latency();
        t_blank();
        t_flash();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule